// File: doc/BRIEF.md
# Word-Wide CRC32 Folding Engine

The engine keeps a running 32-bit CRC over a byte stream and folds up to eight bytes into it on every accepted beat. It does not use a lookup table or shift one bit at a time. Each beat is reduced with two carry-less multiplies against fixed constants, a Barrett reduction. The first multiply is by the precomputed quotient of x^96 divided by the generator. The second is by the generator itself.

Three polynomial conventions are supported:
- reflected CRC32;
- reflected CRC32C;
- MSB-first (non-reflected) CRC32.

A beat may carry fewer than eight bytes. This covers an unaligned head or a short tail of a buffer. For such a beat the block realigns the bytes and splits the CRC, so that the result equals folding those bytes one at a time.

The caller pulses `start` with a seed and a mode, streams beats, and reads `crc_out` one cycle after the last beat. Initial inversion and the final XOR belong to the caller.

Top module: `crc_fold_engine`

## Requirements
- R1: While `rst_n` is low, `crc_out` is 0 and `in_ready` is 0. From the first clock edge after reset is released, `in_ready` is 1 and stays 1.
- R2: A `start` pulse without an accepted beat loads `seed` into `crc_out` on the next cycle. `start` also latches `mode`.
- R3: With mode 2'b00 (reflected CRC32, generator 0xEDB88320 shifted right), `crc_out` equals a bit-serial LSB-first CRC of the accepted bytes. Byte k of a beat sits at `in_data[8k+7:8k]` and is earlier in the stream than byte k+1.
- R4: With mode 2'b01 (reflected CRC32C, generator 0x82F63B78), `crc_out` equals the bit-serial LSB-first CRC with that generator.
- R5: With mode[1]=1 (MSB-first CRC32, generator 0x04C11DB7), `crc_out` equals a bit-serial MSB-first CRC in which each byte enters at bits 31:24. mode[0] is ignored in this mode.
- R6: A beat with `in_bytes`=n (1..7) folds only lanes 0..n-1. The contents of lanes n..7 have no effect.
- R7: A beat with `in_bytes`=0 leaves the CRC unchanged. Values 9..15 are treated as 8.
- R8: When `start` and an accepted beat fall in the same cycle, the beat is folded onto the new seed under the new mode.
- R9: Without `start`, the `mode` input is ignored. Without `start` or an accepted beat, `crc_out` holds its value.
- R10: Beats are accepted back to back, one per cycle. Each beat's result appears on `crc_out` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load seed and latch mode |
| seed | input | 32 | Initial CRC value |
| mode | input | 2 | Bit 1: MSB-first; bit 0: CRC32C generator (reflected only) |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Engine accepts beats |
| in_data | input | 64 | Beat bytes, stream order from lane 0 upward |
| in_bytes | input | 4 | Number of valid lanes, 0..8 |
| crc_out | output | 32 | Running CRC state |

## Verification
Two functions can fall in the same cycle: loading a seed and folding a beat. The bench provokes this by raising `start` in the same cycle as a valid beat, across all three modes and assorted byte counts. The result is judged against a bit-serial model that first replaces the state with the seed and then folds the beat's bytes. A second overlap is a beat that arrives while the `mode` pin is changing. Here the model keeps the mode latched at the last start, and the bench expects no effect from the pin.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned NBYTES = WORD_W / 8;
  localparam int unsigned CNT_W  = $clog2(NBYTES + 1) + 1;

  // Quotients floor(x^96 / G) with the x^64 term implicit
  localparam logic [WORD_W-1:0] QT_REF_IEEE = 64'h5a72d812fb808b20;
  localparam logic [WORD_W-1:0] QT_REF_CAST = 64'ha434f61c6f5389f8;
  localparam logic [WORD_W-1:0] QT_MSB_IEEE = 64'h04d101df481b4e5a;
  localparam logic [CRC_W-1:0]  G_REF_IEEE  = 32'hEDB88320;
  localparam logic [CRC_W-1:0]  G_REF_CAST  = 32'h82F63B78;
  localparam logic [CRC_W-1:0]  G_MSB_IEEE  = 32'h04C11DB7;

  typedef struct packed {
    logic msb_first;
    logic castagnoli;
  } crc_mode_t;

  function automatic logic [CNT_W-1:0] clamp_count(logic [CNT_W-1:0] n);
    return (n > CNT_W'(NBYTES)) ? CNT_W'(NBYTES) : n;
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(int unsigned nb);
    if (nb >= NBYTES) return '1;
    return (WORD_W'(1) << (8 * nb)) - WORD_W'(1);
  endfunction

  // Reflected: bytes slide to the top lanes, CRC rides along with them
  function automatic logic [WORD_W-1:0] ref_operand(logic [WORD_W-1:0] d,
                                                    int unsigned nb,
                                                    logic [CRC_W-1:0] c);
    if (nb == 0) return '0;
    return (({{(WORD_W-CRC_W){1'b0}}, c} ^ (d & lane_mask(nb))) << (WORD_W - 8 * nb));
  endfunction

  function automatic logic [CRC_W-1:0] ref_spill(logic [CRC_W-1:0] c, int unsigned nb);
    if (8 * nb >= CRC_W) return '0;
    return c >> (8 * nb);
  endfunction

  // MSB-first: bytes packed at the low end, first byte most significant
  function automatic logic [WORD_W-1:0] msb_operand(logic [WORD_W-1:0] d,
                                                    int unsigned nb,
                                                    logic [CRC_W-1:0] c);
    logic [WORD_W-1:0] be;
    be = '0;
    if (nb == 0) return '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (k < int'(nb))
        be = be | ({{(WORD_W-8){1'b0}}, d[8*k +: 8]} << (8 * (int'(nb) - 1 - k)));
    end
    return be ^ ({c, {(WORD_W-CRC_W){1'b0}}} >> (WORD_W - 8 * nb));
  endfunction

  function automatic logic [CRC_W-1:0] msb_spill(logic [CRC_W-1:0] c, int unsigned nb);
    if (8 * nb >= CRC_W) return '0;
    return c << (8 * nb);
  endfunction
endpackage

// File: rtl/crc_clmul.sv
module crc_clmul #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  logic [2*W-1:0] pp [W];

  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = b[i] ? ({{W{1'b0}}, a} << i) : '0;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < W; i++) prod = prod ^ pp[i];
  end
endmodule

// File: rtl/crc_word_align.sv
module crc_word_align
  import crc_fold_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic [CRC_W-1:0]  crc,
  input  logic              msb_first,
  output logic [WORD_W-1:0] operand,
  output logic [CRC_W-1:0]  spill
);
  logic [CNT_W-1:0] n_eff;
  int unsigned nb;

  always_comb begin
    n_eff = clamp_count(nbytes);
    nb    = int'(n_eff);
    if (msb_first) begin
      operand = msb_operand(data, nb, crc);
      spill   = msb_spill(crc, nb);
    end else begin
      operand = ref_operand(data, nb, crc);
      spill   = ref_spill(crc, nb);
    end
  end
endmodule

// File: rtl/crc_barrett_step.sv
module crc_barrett_step
  import crc_fold_pkg::*;
(
  input  logic [WORD_W-1:0] operand,
  input  crc_mode_t         md,
  output logic [CRC_W-1:0]  rem
);
  logic [WORD_W-1:0]   qt;
  logic [CRC_W-1:0]    gen;
  logic [WORD_W-1:0]   gen_op;
  logic [2*WORD_W-1:0] prod_q;
  logic [2*WORD_W-1:0] prod_g;
  logic [WORD_W-1:0]   est;

  always_comb begin
    if (md.msb_first) begin
      qt  = QT_MSB_IEEE;
      gen = G_MSB_IEEE;
    end else if (md.castagnoli) begin
      qt  = QT_REF_CAST;
      gen = G_REF_CAST;
    end else begin
      qt  = QT_REF_IEEE;
      gen = G_REF_IEEE;
    end
    gen_op = md.msb_first ? {{(WORD_W-CRC_W){1'b0}}, gen}
                          : {gen, {(WORD_W-CRC_W){1'b0}}};
  end

  crc_clmul #(.W(WORD_W)) u_mul_q (.a(operand), .b(qt), .prod(prod_q));

  // quotient estimate: high product half (MSB-first) or its reflected twin
  assign est = md.msb_first ? (prod_q[2*WORD_W-1:WORD_W] ^ operand)
                            : ((prod_q[WORD_W-1:0] << 1) ^ operand);

  crc_clmul #(.W(WORD_W)) u_mul_g (.a(est), .b(gen_op), .prod(prod_g));

  assign rem = md.msb_first ? prod_g[CRC_W-1:0]
                            : prod_g[2*WORD_W-2 -: CRC_W];
endmodule

// File: rtl/crc_fold_engine.sv
module crc_fold_engine
  import crc_fold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] seed,
  input  logic [1:0]  mode,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_data,
  input  logic [3:0]  in_bytes,
  output logic [31:0] crc_out
);
  logic             rdy_q;
  logic [CRC_W-1:0] crc_q;
  crc_mode_t        mode_q;
  crc_mode_t        mode_eff;
  logic [CRC_W-1:0] base_crc;
  logic [WORD_W-1:0] operand;
  logic [CRC_W-1:0] spill;
  logic [CRC_W-1:0] rem;
  logic [CRC_W-1:0] next_crc;
  logic             fold_fire;

  assign mode_eff  = start ? crc_mode_t'(mode) : mode_q;
  assign base_crc  = start ? seed : crc_q;
  assign fold_fire = in_valid && rdy_q && (in_bytes != '0);

  crc_word_align u_align (
    .data     (in_data),
    .nbytes   (CNT_W'(in_bytes)),
    .crc      (base_crc),
    .msb_first(mode_eff.msb_first),
    .operand  (operand),
    .spill    (spill)
  );

  crc_barrett_step u_step (
    .operand(operand),
    .md     (mode_eff),
    .rem    (rem)
  );

  assign next_crc = rem ^ spill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      crc_q  <= '0;
      mode_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (start) mode_q <= crc_mode_t'(mode);
      if (fold_fire)  crc_q <= next_crc;
      else if (start) crc_q <= seed;
    end
  end

  assign in_ready = rdy_q;
  assign crc_out  = crc_q;
endmodule

// File: rtl/crc_fold_chk.sv
module crc_fold_chk
  import crc_fold_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] seed,
  input logic [1:0]  mode,
  input logic        in_valid,
  input logic        in_ready,
  input logic [3:0]  in_bytes,
  input logic [31:0] crc_out,
  input crc_mode_t   mode_q,
  input logic        fold_fire
);
  // R1
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> in_ready);

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fold_fire) |=> (crc_out == $past(seed)));

  // R2
  mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mode_q == crc_mode_t'($past(mode))));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(mode_q));

  // R9
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !fold_fire) |=> $stable(crc_out));

  // R7
  empty_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_bytes == 4'd0 && !start) |=> $stable(crc_out));
endmodule

bind crc_fold_engine crc_fold_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .mode(mode),
  .in_valid(in_valid), .in_ready(in_ready), .in_bytes(in_bytes),
  .crc_out(crc_out), .mode_q(mode_q), .fold_fire(fold_fire)
);

// File: tb/crc_fold_engine_bench.sv
`timescale 1ns/100ps
module crc_fold_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] seed = '0;
  logic [1:0]  mode = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [3:0]  in_bytes = '0;
  logic [31:0] crc_out;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [31:0] val;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  logic [31:0] exp_crc = '0;
  logic [1:0]  exp_mode = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  crc_fold_engine u_crc_fold_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .mode(mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_bytes(in_bytes), .crc_out(crc_out)
  );

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bit-serial reference, one byte
  function automatic logic [31:0] ref_byte(logic [1:0] md, logic [31:0] c, logic [7:0] b);
    logic [31:0] g;
    g = md[0] ? 32'h82F63B78 : 32'hEDB88320;
    if (md[1]) begin
      c = c ^ {b, 24'h0};
      for (int i = 0; i < 8; i++) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
    end else begin
      c = c ^ {24'h0, b};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ g) : (c >> 1);
    end
    return c;
  endfunction

  function automatic string mode_tag(logic [1:0] md);
    if (md[1]) return "R5 msb-first";
    return md[0] ? "R4 reflected-C" : "R3 reflected";
  endfunction

  task automatic model_beat(logic [63:0] d, int n);
    int nn;
    nn = (n > 8) ? 8 : n;
    for (int k = 0; k < nn; k++) exp_crc = ref_byte(exp_mode, exp_crc, d[8*k +: 8]);
  endtask

  task automatic push(logic [31:0] v, string tag);
    sb_item_t it;
    it.due = cyc + 1;
    it.val = v;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_start(logic [31:0] sd, logic [1:0] md, bit beat, logic [63:0] d, int n, string tag);
    @(negedge clk);
    start = 1'b1; seed = sd; mode = md;
    in_valid = beat; in_data = d; in_bytes = 4'(n);
    exp_crc = sd; exp_mode = md;
    if (beat) model_beat(d, n);
    push(exp_crc, tag);
  endtask

  // mode pin is scrambled on every beat: R9 says it is ignored
  task automatic do_beat(logic [63:0] d, int n, string tag);
    @(negedge clk);
    start = 1'b0; mode = 2'($urandom);
    in_valid = 1'b1; in_data = d; in_bytes = 4'(n);
    model_beat(d, n);
    push(exp_crc, tag);
  endtask

  task automatic do_idle(int k, string tag);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0; mode = 2'($urandom);
      in_data = {$urandom, $urandom}; in_bytes = 4'($urandom);
    end
    push(exp_crc, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    sb_item_t it;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      check(crc_out, it.val, it.tag);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  localparam logic [63:0] DIGITS8 = 64'h3837363534333231;

  initial begin
    repeat (3) @(negedge clk);
    check({31'h0, in_ready}, 32'h0, "R1 ready low in reset");
    check(crc_out, 32'h0, "R1 crc zero in reset");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({31'h0, in_ready}, 32'h1, "R1 ready after reset");

    // R2 seed load, then idle hold
    do_start(32'hA5A5_1234, 2'b00, 1'b0, '0, 0, "R2 seed load");
    do_idle(3, "R9 idle hold");

    // R3/R4/R5 known check values over nine ASCII digits (seed all-ones, result inverted)
    do_start(32'hFFFF_FFFF, 2'b00, 1'b0, '0, 0, "R2 seed");
    do_beat(DIGITS8, 8, "R3 digits");
    do_beat({56'hDEAD_BEEF_C0FF_EE, 8'h39}, 1, "R6 tail lane");
    push(32'hCBF43926 ^ 32'hFFFF_FFFF, "R3 known value");
    do_start(32'hFFFF_FFFF, 2'b01, 1'b0, '0, 0, "R2 seed");
    do_beat(DIGITS8, 8, "R4 digits");
    do_beat({56'h1234_5678_9ABC_DE, 8'h39}, 1, "R6 tail lane");
    push(32'hE3069283 ^ 32'hFFFF_FFFF, "R4 known value");
    do_start(32'hFFFF_FFFF, 2'b11, 1'b0, '0, 0, "R2 seed");
    do_beat(DIGITS8, 8, "R5 digits");
    do_beat({56'hFFFF_FFFF_FFFF_FF, 8'h39}, 1, "R6 tail lane");
    push(32'hFC891918 ^ 32'hFFFF_FFFF, "R5 known value");

    // R7 empty beat and oversized count
    do_beat({$urandom, $urandom}, 0, "R7 zero count");
    do_beat({$urandom, $urandom}, 12, "R7 count above 8");
    do_beat({$urandom, $urandom}, 15, "R7 count 15");

    // R8 start with a beat in the same cycle, every mode and several counts
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 8; n += 3) begin
        do_start($urandom, 2'(m), 1'b1, {$urandom, $urandom}, n, "R8 start+beat");
        do_beat({$urandom, $urandom}, 8, "R10 back-to-back");
      end
    end

    // head / full words / tail streams, random modes (R3 R4 R5 R6 R10)
    for (int s = 0; s < 400; s++) begin
      logic [1:0] md;
      int nb;
      md = 2'($urandom);
      do_start($urandom, md, 1'b0, '0, 0, "R2 stream seed");
      nb = 1 + ($urandom % 6);
      for (int b = 0; b < nb; b++) begin
        int n;
        if (b == 0 || b == nb - 1) n = 1 + ($urandom % 8);
        else n = 8;
        do_beat({$urandom, $urandom}, n, mode_tag(md));
      end
      if (($urandom % 4) == 0) do_idle(2, "R9 hold after stream");
    end

    do_idle(3, "R9 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule